// File: doc/BRIEF.md
# Receive Byte Queue with Word Packing

This block sits between a serial receive engine and a host register interface. The engine hands over one byte at a time. The host drains the queue through a single 32-bit read port, and each read of that port removes up to four bytes. A status word tells the host how many bytes are waiting, and flags show when the fill has reached 16, 32 or 64 bytes. Software can then size a burst of port reads from one status read.

The data port always shows the oldest bytes, packed little-endian, with unused upper lanes forced to zero. Asserting the read strobe for one cycle consumes the bytes shown. A one-cycle write with bit 0 set empties the queue and clears both error flags. Reading an empty queue and pushing into a full one are both recorded as sticky errors.

Occupancy is tracked by a three-state machine. The states are EMPTY, HOLD (1 to DEPTH-1 bytes) and FULL. The transitions are named as follows:
- EMPTY→HOLD, "first byte": a byte is accepted.
- HOLD→FULL, "fill": the count reaches DEPTH.
- HOLD→EMPTY, "drain or flush": the count returns to zero.
- FULL→HOLD, "read": a port read frees space.
- FULL→EMPTY, "flush".

Top module: `rxq_pack_top`

## Requirements
- R1: After reset the status word is 0x800 (empty set, count 0, all other bits clear), the data port reads 0, and both error flags are low.
- R2: Status layout: bits 10:4 hold the count of valid bytes, bit 11 is 1 exactly when the count is 0, and bit 0 is 1 exactly when the count is nonzero. Bits 31:12 read 0.
- R3: Status bits 1, 2 and 3 are 1 exactly when the count is at least 16, 32 and 64 respectively.
- R4: The data port presents the oldest byte in bits 7:0 and the k-th oldest byte in bits 8k+7:8k. A read strobe removes min(4, count) bytes, and the next read shows the following bytes.
- R5: When fewer than four bytes are queued, they appear in the low lanes and every lane at or above the count reads 0.
- R6: A reset-register write with bit 0 = 1 empties the queue and clears both error flags. A write with bit 0 = 0 changes nothing.
- R7: A read strobe while the queue is empty sets the sticky underrun flag. The count stays at 0 and the port reads 0.
- R8: A push while the count equals DEPTH is dropped and sets the sticky overflow flag. Queued contents and count are unchanged.
- R9: A push and a read in the same cycle both take effect. The read sees the bytes queued before the push, and the new count is count + 1 - min(4, count).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_valid | input | 1 | Serial engine offers a byte this cycle |
| push_byte | input | 8 | Byte from the serial engine |
| rd_req | input | 1 | Host reads the data port this cycle |
| rd_data | output | 32 | Packed head word (peek) |
| q_rst_wr | input | 1 | Host write to the reset register |
| q_rst_bit0 | input | 1 | Bit 0 of that write |
| status | output | 32 | Count, empty, ready and threshold flags |
| err_underrun | output | 1 | Sticky: read while empty |
| err_overflow | output | 1 | Sticky: push while full |

## Verification
The bench builds the block with its default depth of 64 bytes. At that depth the 64-byte threshold coincides with FULL, so all three threshold flags, the fill transition and overflow are all reachable. Full drains exercise the pointer wrap. Odd-length fills exercise the 1-, 2- and 3-byte partial words.

// File: rtl/rxq_pack_pkg.sv
package rxq_pack_pkg;
    localparam int LANES  = 4;
    localparam int BYTE_W = 8;
    localparam int WORD_W = LANES * BYTE_W;

    // status word bit positions (host software decodes these)
    localparam int ST_READY = 0;
    localparam int ST_GE16  = 1;
    localparam int ST_GE32  = 2;
    localparam int ST_GE64  = 3;
    localparam int ST_CNT_LO = 4;
    localparam int ST_CNT_W  = 7;
    localparam int ST_EMPTY = 11;

    typedef enum logic [1:0] {
        OCC_EMPTY = 2'd0,
        OCC_HOLD  = 2'd1,
        OCC_FULL  = 2'd2
    } occ_state_e;
endpackage

// File: rtl/rxq_byte_store.sv
module rxq_byte_store
    import rxq_pack_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int PTR_W = $clog2(DEPTH),
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              wr_en_i,
    input  logic [BYTE_W-1:0] wr_byte_i,
    input  logic [2:0]        adv_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic [WORD_W-1:0] win_o
);
    logic [BYTE_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr_q;
    logic [PTR_W-1:0]  rd_ptr_q;

    // pointers wrap naturally: DEPTH is a power of two
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
        end else if (clear_i) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
        end else begin
            if (wr_en_i) begin
                wr_ptr_q <= wr_ptr_q + PTR_W'(1);
            end
            rd_ptr_q <= rd_ptr_q + PTR_W'(adv_i);
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            mem[wr_ptr_q] <= wr_byte_i;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [PTR_W-1:0] idx;
        assign idx = rd_ptr_q + PTR_W'(g);
        assign win_o[BYTE_W*g +: BYTE_W] = (cnt_i > CNT_W'(g)) ? mem[idx] : '0;
    end
endmodule

// File: rtl/rxq_fill_ctrl.sv
module rxq_fill_ctrl
    import rxq_pack_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_valid_i,
    input  logic             rd_req_i,
    input  logic             flush_i,
    output logic             push_ok_o,
    output logic [2:0]       pop_n_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             is_empty_o,
    output logic             is_full_o,
    output logic             underrun_o,
    output logic             overflow_o
);
    localparam logic [CNT_W-1:0] LANE_CNT = CNT_W'(LANES);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    occ_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             pop;

    assign pop       = rd_req_i && !flush_i;
    assign push_ok_o = push_valid_i && !is_full_o && !flush_i;
    assign pop_n_o   = !pop ? 3'd0 : ((cnt_q >= LANE_CNT) ? 3'd4 : cnt_q[2:0]);
    assign cnt_d     = flush_i ? '0 : (cnt_q + CNT_W'(push_ok_o) - CNT_W'(pop_n_o));
    assign cnt_o     = cnt_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OCC_EMPTY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OCC_EMPTY: if (cnt_d != '0) state_d = OCC_HOLD;      // first byte
            OCC_HOLD: begin
                if (cnt_d == '0)            state_d = OCC_EMPTY; // drain or flush
                else if (cnt_d == FULL_CNT) state_d = OCC_FULL;  // fill
            end
            OCC_FULL: begin
                if (cnt_d == '0)            state_d = OCC_EMPTY; // flush
                else if (cnt_d != FULL_CNT) state_d = OCC_HOLD;  // read
            end
            default: state_d = OCC_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        is_empty_o = 1'b0;
        is_full_o  = 1'b0;
        unique case (state_q)
            OCC_EMPTY: is_empty_o = 1'b1;
            OCC_HOLD:  ;
            OCC_FULL:  is_full_o  = 1'b1;
            default:   is_empty_o = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            underrun_o <= 1'b0;
            overflow_o <= 1'b0;
        end else if (flush_i) begin
            underrun_o <= 1'b0;
            overflow_o <= 1'b0;
        end else begin
            if (rd_req_i && is_empty_o)     underrun_o <= 1'b1;
            if (push_valid_i && is_full_o)  overflow_o <= 1'b1;
        end
    end
endmodule

// File: rtl/rxq_stat_fmt.sv
module rxq_stat_fmt
    import rxq_pack_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              is_empty_i,
    output logic [WORD_W-1:0] status_o
);
    logic [31:0] cnt_ext;
    assign cnt_ext = 32'(cnt_i);

    always_comb begin
        status_o = '0;
        status_o[ST_READY] = !is_empty_i;
        status_o[ST_GE16]  = cnt_ext >= 32'd16;
        status_o[ST_GE32]  = cnt_ext >= 32'd32;
        status_o[ST_GE64]  = cnt_ext >= 32'd64;
        status_o[ST_CNT_LO +: ST_CNT_W] = cnt_ext[ST_CNT_W-1:0];
        status_o[ST_EMPTY] = is_empty_i;
    end
endmodule

// File: rtl/rxq_pack_top.sv
module rxq_pack_top
    import rxq_pack_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        push_valid,
    input  logic [7:0]  push_byte,
    input  logic        rd_req,
    output logic [31:0] rd_data,
    input  logic        q_rst_wr,
    input  logic        q_rst_bit0,
    output logic [31:0] status,
    output logic        err_underrun,
    output logic        err_overflow
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             flush;
    logic             push_ok;
    logic [2:0]       pop_n;
    logic [CNT_W-1:0] cnt;
    logic             is_empty;
    logic             is_full;

    assign flush = q_rst_wr && q_rst_bit0;

    rxq_fill_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .push_valid_i(push_valid), .rd_req_i(rd_req), .flush_i(flush),
        .push_ok_o(push_ok), .pop_n_o(pop_n), .cnt_o(cnt),
        .is_empty_o(is_empty), .is_full_o(is_full),
        .underrun_o(err_underrun), .overflow_o(err_overflow)
    );

    rxq_byte_store #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_store (
        .clk(clk), .rst_n(rst_n), .clear_i(flush),
        .wr_en_i(push_ok), .wr_byte_i(push_byte),
        .adv_i(pop_n), .cnt_i(cnt), .win_o(rd_data)
    );

    rxq_stat_fmt #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_stat (
        .cnt_i(cnt), .is_empty_i(is_empty), .status_o(status)
    );
endmodule

// File: rtl/rxq_pack_chk.sv
module rxq_pack_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        push_valid,
    input logic        rd_req,
    input logic [31:0] rd_data,
    input logic        q_rst_wr,
    input logic        q_rst_bit0,
    input logic [31:0] status,
    input logic        err_underrun,
    input logic        err_overflow
);
    logic flush;
    assign flush = q_rst_wr && q_rst_bit0;

    // R3: tiers nest
    a_r3_tiers_nest: assert property (@(posedge clk) disable iff (!rst_n)
        status[3] |-> (status[2] && status[1]));

    // R5: a single queued byte leaves the upper lanes at zero
    a_r5_upper_lanes_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (status[10:4] == 7'd1) |-> (rd_data[31:8] == 24'd0));

    // R6: flush empties and clears errors
    a_r6_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (status[11] && !err_underrun && !err_overflow));

    // R7: read while empty raises underrun, count stays zero
    a_r7_underrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && status[11] && !flush && !push_valid) |=> (err_underrun && status[11]));

    // R8: push into full leaves the count alone
    a_r8_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && status[3] && status[10:4] == 7'd64 && !rd_req && !flush)
        |=> ($stable(status[10:4]) && err_overflow));

    // R4: a read with four or more queued removes exactly four
    a_r4_pop_four: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !push_valid && !flush && status[10:4] >= 7'd4)
        |=> (status[10:4] == $past(status[10:4]) - 7'd4));
endmodule

bind rxq_pack_top rxq_pack_chk chk_i (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .rd_req(rd_req),
    .rd_data(rd_data), .q_rst_wr(q_rst_wr), .q_rst_bit0(q_rst_bit0),
    .status(status), .err_underrun(err_underrun), .err_overflow(err_overflow)
);

// File: tb/rxq_pack_top_tb.sv
module rxq_pack_top_tb_top;
    localparam int DEPTH = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_valid = 1'b0;
    logic [7:0]  push_byte = 8'h00;
    logic        rd_req = 1'b0;
    logic [31:0] rd_data;
    logic        q_rst_wr = 1'b0;
    logic        q_rst_bit0 = 1'b0;
    logic [31:0] status;
    logic        err_underrun;
    logic        err_overflow;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    byte unsigned mq[$];
    bit exp_unf = 1'b0;
    bit exp_ovf = 1'b0;

    always #5 clk = ~clk;

    rxq_pack_top #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_byte(push_byte),
        .rd_req(rd_req), .rd_data(rd_data), .q_rst_wr(q_rst_wr), .q_rst_bit0(q_rst_bit0),
        .status(status), .err_underrun(err_underrun), .err_overflow(err_overflow)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_stat(input int n);
        logic [31:0] s = '0;
        s[0] = (n != 0);
        s[1] = (n >= 16);
        s[2] = (n >= 32);
        s[3] = (n >= 64);
        s[10:4] = 7'(n);
        s[11] = (n == 0);
        return s;
    endfunction

    // expected head word from the model, popping min(4,size) when take is set
    function automatic logic [31:0] model_word(input bit take);
        logic [31:0] w = '0;
        int n = (mq.size() < 4) ? mq.size() : 4;
        for (int i = 0; i < n; i++) w[8*i +: 8] = mq[i];
        if (take) for (int i = 0; i < n; i++) void'(mq.pop_front());
        return w;
    endfunction

    task automatic chk_status(input string req);
        logic [31:0] e = exp_stat(mq.size());
        check(status == e, req, status, e);
    endtask

    task automatic chk_errs(input string req);
        check(err_underrun == exp_unf && err_overflow == exp_ovf, req,
              {30'd0, err_overflow, err_underrun}, {30'd0, exp_ovf, exp_unf});
    endtask

    // driver: push one byte, model follows
    task automatic push(input byte unsigned b);
        @(negedge clk);
        push_valid = 1'b1; push_byte = b;
        if (mq.size() < DEPTH) mq.push_back(b); else exp_ovf = 1'b1;
        @(negedge clk);
        push_valid = 1'b0;
    endtask

    // monitor: one port read, compared against the model
    task automatic port_read(input string req);
        logic [31:0] e;
        @(negedge clk);
        rd_req = 1'b1;
        if (mq.size() == 0) exp_unf = 1'b1;
        #1;
        e = model_word(1'b1);
        check(rd_data == e, req, rd_data, e);
        @(negedge clk);
        rd_req = 1'b0;
    endtask

    task automatic rst_write(input bit b0);
        @(negedge clk);
        q_rst_wr = 1'b1; q_rst_bit0 = b0;
        if (b0) begin
            mq.delete(); exp_unf = 1'b0; exp_ovf = 1'b0;
        end
        @(negedge clk);
        q_rst_wr = 1'b0; q_rst_bit0 = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(status == 32'h800, "R1 status", status, 32'h800);
        check(rd_data == 32'h0, "R1 data", rd_data, 32'h0);
        chk_errs("R1 errs");

        // R5, R2: single byte
        push(8'hA5);
        chk_status("R2 one byte");
        port_read("R5 one byte");
        chk_status("R2 drained");

        // R4, R5: seven bytes -> full word then 3-byte partial
        for (int i = 0; i < 7; i++) push(8'(8'h10 + i));
        chk_status("R2 seven");
        port_read("R4 first word");
        chk_status("R4 count after pop");
        port_read("R5 three-byte partial");
        // R5: two-byte partial
        push(8'h77); push(8'h88);
        port_read("R5 two-byte partial");

        // R7: read while empty
        port_read("R7 empty data zero");
        chk_status("R7 count zero");
        chk_errs("R7 underrun set");

        // R6: bit0=0 write has no effect; bit0=1 clears errors
        push(8'h3C);
        rst_write(1'b0);
        chk_status("R6 bit0 zero ignored");
        chk_errs("R6 bit0 zero keeps errs");
        rst_write(1'b1);
        chk_status("R6 flushed");
        chk_errs("R6 errs cleared");
        check(rd_data == 32'h0, "R6 data after flush", rd_data, 32'h0);

        // R3: thresholds and R8 overflow
        for (int i = 0; i < 64; i++) begin
            push(8'(i * 3 + 1));
            if (i == 14 || i == 15 || i == 31 || i == 62 || i == 63) chk_status("R3 tier");
        end
        push(8'hEE);
        chk_status("R8 count held");
        chk_errs("R8 overflow set");
        for (int i = 0; i < 16; i++) port_read("R8 contents intact");
        chk_status("R4 drained");

        // R9: push and read together
        for (int i = 0; i < 5; i++) push(8'(8'hC0 + i));
        @(negedge clk);
        rd_req = 1'b1; push_valid = 1'b1; push_byte = 8'hD9;
        #1;
        e = model_word(1'b1);
        mq.push_back(8'hD9);
        check(rd_data == e, "R9 read sees old bytes", rd_data, e);
        @(negedge clk);
        rd_req = 1'b0; push_valid = 1'b0;
        chk_status("R9 count");
        port_read("R9 follow-up word");
        chk_errs("R9 errs");

        rst_write(1'b1);
        chk_status("R6 final flush");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule